// File: doc/BRIEF.md
# Prefix-Controlled Carry ALU

This block is the 8-bit arithmetic and logic unit of a small accumulator-style core. Each instruction gives it two operands, a source value `si` and a second operand `snd` that is also the destination, along with an opcode. After one clock it returns a registered result and three registered flags: Carry, Zero and Sign. The block has no add-with-carry or subtract-with-borrow opcode. Each arithmetic or shift opcode instead has its own fixed default carry input.

A prefix instruction controls chaining. Issuing the prefix arms a two-state controller. The prefix writes nothing and leaves the flags alone. The next valid instruction then uses the stored Carry flag as its carry input in place of its default, and that instruction disarms the controller. A 16-bit add is therefore ADD, prefix, ADD, and wider chains repeat the prefix before each upper byte.

The controller has two states. `ST_IDLE` means no override is pending. `ST_ARMED` means the next valid instruction takes its carry input from the Carry flag. There are four transitions. *arm* goes from `ST_IDLE` to `ST_ARMED` on a prefix. *rearm* stays in `ST_ARMED` on another prefix. *consume* goes from `ST_ARMED` to `ST_IDLE` on any other valid instruction. *hold* keeps either state on a cycle with no valid instruction.

Top module: `pcc_alu`

## Requirements
- R1: After reset the result is 0x00, all three flags are 0, `res_wr` is 0 and no override is pending.
- R2: Opcode 0 (ADD) writes SI + SND + cin modulo 256, with a default cin of 0. Carry becomes the carry out of bit 7.
- R3: Opcode 1 (SUB) writes SI + ~SND + cin, with a default cin of 1, so the default result is SI − SND. Carry becomes the carry out of bit 7, which is 1 when no borrow occurs.
- R4: Opcode 2 (CMPU) updates the flags exactly as SUB would, but does not write: `res_wr` stays 0 and the result stays unchanged.
- R5: Opcodes 3 (AND), 4 (OR) and 5 (XOR) write SI op SND and update Zero and Sign, leaving Carry unchanged.
- R6: Opcode 6 (SHL) writes {SND[6:0], cin} and opcode 7 (SHR) writes {cin, SND[7:1]}, each with a default cin of 0. Carry becomes the bit shifted out.
- R7: Every flag-updating opcode sets Zero when its 8-bit outcome is 0x00 and sets Sign to bit 7 of that outcome. For CMPU the outcome is the difference.
- R8: Opcode 8 (prefix) writes nothing and changes no flag. It makes the next valid instruction use the current Carry flag as its carry input instead of the default.
- R9: The override is cleared by exactly one following valid instruction of any opcode. A prefix that follows a prefix keeps it armed. Cycles with `op_valid` low do not clear it.
- R10: Opcodes 9 to 15 write nothing and change no flag, but they do consume a pending override.
- R11: Chaining ADD or SUB per byte, with a prefix before each upper byte, gives the correct 16-bit and 24-bit sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 4 | Opcode, encoded as in the requirements |
| si | input | 8 | Source operand |
| snd | input | 8 | Second operand and destination value |
| result | output | 8 | Last written result |
| res_wr | output | 1 | High for one cycle after an instruction that wrote `result` |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |

## Verification
Two things can fall in the same clock edge: consuming the override and updating the Carry flag that the override read. A chained upper-byte ADD or SUB both uses the old Carry as its input and replaces it with its own carry out, so the bench runs back-to-back prefix/arithmetic sequences and carry-producing low bytes. Each step is judged against a scoreboard model, and each assembled 16-bit and 24-bit word is compared with plain wide arithmetic. The bench also probes the consume edge by placing a boolean, an undefined opcode, idle cycles or a second prefix right after the prefix.

// File: rtl/pcc_alu_pkg.sv
package pcc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMPU = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_PF   = 4'd8
    } alu_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } pf_state_e;

endpackage

// File: rtl/pcc_prefix_fsm.sv
module pcc_prefix_fsm
    import pcc_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic is_pf,
    output logic armed
);

    pf_state_e state, state_nx;

    // next-state logic: arm, rearm, consume, hold
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (op_valid && is_pf) state_nx = ST_ARMED;        // arm
            end
            ST_ARMED: begin
                if (op_valid && is_pf)       state_nx = ST_ARMED;  // rearm
                else if (op_valid)           state_nx = ST_IDLE;   // consume
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        armed = (state == ST_ARMED);
    end

endmodule

// File: rtl/pcc_alu_core.sv
module pcc_alu_core
    import pcc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   opc,
    input  logic [W-1:0] si,
    input  logic [W-1:0] snd,
    input  logic         armed,
    input  logic         c_now,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         z_out,
    output logic         s_out,
    output logic         wr,
    output logic         upd
);

    localparam int WE = W + 1;

    alu_op_e        op;
    logic           cin_def;
    logic           cin;
    logic [WE-1:0]  sum;
    logic [W-1:0]   flag_src;

    always_comb begin
        op      = alu_op_e'(opc);
        cin_def = (op == OP_SUB) || (op == OP_CMPU);
        cin     = armed ? c_now : cin_def;
    end

    always_comb begin
        res      = '0;
        c_out    = c_now;
        wr       = 1'b0;
        upd      = 1'b0;
        sum      = '0;
        flag_src = '0;
        case (op)
            OP_ADD: begin
                sum      = {1'b0, si} + {1'b0, snd} + {{W{1'b0}}, cin};
                res      = sum[W-1:0];
                c_out    = sum[W];
                wr       = 1'b1;
                upd      = 1'b1;
                flag_src = sum[W-1:0];
            end
            OP_SUB, OP_CMPU: begin
                sum      = {1'b0, si} + {1'b0, ~snd} + {{W{1'b0}}, cin};
                res      = sum[W-1:0];
                c_out    = sum[W];
                wr       = (op == OP_SUB);
                upd      = 1'b1;
                flag_src = sum[W-1:0];
            end
            OP_AND: begin
                res = si & snd; wr = 1'b1; upd = 1'b1; flag_src = si & snd;
            end
            OP_OR: begin
                res = si | snd; wr = 1'b1; upd = 1'b1; flag_src = si | snd;
            end
            OP_XOR: begin
                res = si ^ snd; wr = 1'b1; upd = 1'b1; flag_src = si ^ snd;
            end
            OP_SHL: begin
                res      = {snd[W-2:0], cin};
                c_out    = snd[W-1];
                wr       = 1'b1;
                upd      = 1'b1;
                flag_src = {snd[W-2:0], cin};
            end
            OP_SHR: begin
                res      = {cin, snd[W-1:1]};
                c_out    = snd[0];
                wr       = 1'b1;
                upd      = 1'b1;
                flag_src = {cin, snd[W-1:1]};
            end
            default: ;
        endcase
    end

    always_comb begin
        z_out = (flag_src == '0);
        s_out = flag_src[W-1];
    end

endmodule

// File: rtl/pcc_alu.sv
module pcc_alu
    import pcc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] si,
    input  logic [W-1:0] snd,
    output logic [W-1:0] result,
    output logic         res_wr,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_s
);

    logic           armed;
    logic           is_pf;
    logic [W-1:0]   core_res;
    logic           core_c, core_z, core_s, core_wr, core_upd;

    always_comb is_pf = (op_code == OP_PF);

    pcc_prefix_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .is_pf    (is_pf),
        .armed    (armed)
    );

    pcc_alu_core #(.W(W)) u_core (
        .opc   (op_code),
        .si    (si),
        .snd   (snd),
        .armed (armed),
        .c_now (flag_c),
        .res   (core_res),
        .c_out (core_c),
        .z_out (core_z),
        .s_out (core_s),
        .wr    (core_wr),
        .upd   (core_upd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            res_wr <= 1'b0;
            flag_c <= 1'b0;
            flag_z <= 1'b0;
            flag_s <= 1'b0;
        end else begin
            res_wr <= op_valid && core_wr;
            if (op_valid && core_wr) result <= core_res;
            if (op_valid && core_upd) begin
                flag_c <= core_c;
                flag_z <= core_z;
                flag_s <= core_s;
            end
        end
    end

endmodule

// File: rtl/pcc_alu_chk.sv
module pcc_alu_chk
    import pcc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] si,
    input logic [W-1:0] snd,
    input logic [W-1:0] result,
    input logic         res_wr,
    input logic         flag_c,
    input logic         flag_z,
    input logic         flag_s,
    input logic         armed
);

    logic [W-1:0] diff;
    always_comb diff = si - snd;

    a_r3_sub_default: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && op_valid && op_code == OP_SUB) |=> (result == $past(diff)));

    a_r4_cmpu_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMPU) |=> (!res_wr && $stable(result)));

    a_r5_bool_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
        |=> $stable(flag_c));

    a_r6_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SHL) |=> (flag_c == $past(snd[W-1])));

    a_r7_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> ((flag_z == (result == '0)) && (flag_s == result[W-1])));

    a_r8_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PF)
        |=> (!res_wr && $stable(flag_c) && $stable(flag_z) && $stable(flag_s)));

    a_r9_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PF) |=> armed);

    a_r9_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && op_valid && op_code != OP_PF) |=> !armed);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !op_valid) |=> armed);

    a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > OP_PF)
        |=> (!res_wr && $stable(flag_c) && $stable(flag_z) && $stable(flag_s)));

endmodule

bind pcc_alu pcc_alu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .si       (si),
    .snd      (snd),
    .result   (result),
    .res_wr   (res_wr),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_s   (flag_s),
    .armed    (armed)
);

// File: tb/tb_pcc_alu.sv
module tb_pcc_alu;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = 4'd0;
    logic [W-1:0] si = '0;
    logic [W-1:0] snd = '0;
    logic [W-1:0] result;
    logic         res_wr;
    logic         flag_c, flag_z, flag_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    logic [W-1:0] m_res = '0;
    logic         m_c = 1'b0, m_z = 1'b0, m_s = 1'b0, m_armed = 1'b0;

    // expected item: {we, res, c, z, s}
    logic [W+3:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] cap_q[$];

    always #4 clk = ~clk;   // 125 MHz

    pcc_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .si(si), .snd(snd), .result(result), .res_wr(res_wr),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s)
    );

    task automatic check(input bit ok, input string tag, input string act, input string expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, expv);
        end
    endtask

    // driver: compute expectation from the requirements and push it
    task automatic issue(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag);
        logic         cin, we, upd, c;
        logic [W:0]   sum;
        logic [W-1:0] r;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; si = a; snd = b;
        cin = m_armed ? m_c : ((op == 4'd1) || (op == 4'd2));
        we = 1'b0; upd = 1'b0; c = m_c; r = '0; sum = '0;
        case (op)
            4'd0: begin sum = {1'b0, a} + {1'b0, b} + cin; r = sum[W-1:0]; c = sum[W]; we = 1; upd = 1; end
            4'd1, 4'd2: begin sum = {1'b0, a} + {1'b0, ~b} + cin; r = sum[W-1:0]; c = sum[W];
                              we = (op == 4'd1); upd = 1; end
            4'd3: begin r = a & b; we = 1; upd = 1; end
            4'd4: begin r = a | b; we = 1; upd = 1; end
            4'd5: begin r = a ^ b; we = 1; upd = 1; end
            4'd6: begin r = {b[W-2:0], cin}; c = b[W-1]; we = 1; upd = 1; end
            4'd7: begin r = {cin, b[W-1:1]}; c = b[0]; we = 1; upd = 1; end
            default: ;
        endcase
        if (upd) begin m_c = c; m_z = (r == '0); m_s = r[W-1]; end
        if (we) m_res = r;
        m_armed = (op == 4'd8);
        exp_q.push_back({we, m_res, m_c, m_z, m_s});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
        end
    endtask

    // monitor: pop and compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && res_wr) cap_q.push_back(result);
            if (exp_q.size() > 0) begin
                logic [W+3:0] e;
                logic [W+3:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {res_wr, result, flag_c, flag_z, flag_s};
                check(a == e, t, $sformatf("%h", a), $sformatf("%h", e));
            end
        end
    end

    task automatic chain(input int nbytes, input bit sub, input logic [23:0] x, input logic [23:0] y);
        logic [23:0] got, want, mask;
        cap_q.delete();
        for (int k = 0; k < nbytes; k++) begin
            if (k > 0) issue(4'd8, 8'h00, 8'h00, "R8 prefix in chain");
            issue(sub ? 4'd1 : 4'd0, x[8*k +: 8], y[8*k +: 8], "R11 chain byte");
        end
        idle(2);
        got = '0;
        for (int k = 0; k < nbytes; k++)
            if (cap_q.size() > 0) got[8*k +: 8] = cap_q.pop_front();
        mask = (nbytes == 2) ? 24'h00FFFF : 24'hFFFFFF;
        want = (sub ? (x - y) : (x + y)) & mask;
        check(got == want, sub ? "R11 chained sub" : "R11 chained add",
              $sformatf("%h", got), $sformatf("%h", want));
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11 actual=timeout expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({result, res_wr, flag_c, flag_z, flag_s} == '0, "R1 reset outputs",
              $sformatf("%h", {result, res_wr, flag_c, flag_z, flag_s}), "0");
        issue(4'd0, 8'h10, 8'h05, "R1 no override after reset");

        // R2 add
        issue(4'd0, 8'h7F, 8'h01, "R2 add sign");
        issue(4'd0, 8'hFF, 8'h01, "R2 add carry zero R7");
        // R3 sub
        issue(4'd1, 8'h05, 8'h03, "R3 sub 5-3");
        issue(4'd1, 8'h03, 8'h05, "R3 sub borrow");
        issue(4'd1, 8'h09, 8'h09, "R3 sub zero R7");
        // R4 cmpu
        issue(4'd2, 8'h0A, 8'h14, "R4 cmpu lt");
        issue(4'd2, 8'h33, 8'h33, "R4 cmpu eq");
        // R5 boolean keeps carry (carry set first)
        issue(4'd0, 8'hF0, 8'h20, "R2 set carry");
        issue(4'd3, 8'hF0, 8'h0F, "R5 and zero");
        issue(4'd4, 8'h80, 8'h01, "R5 or sign");
        issue(4'd5, 8'hAA, 8'h55, "R5 xor");
        // R6 shifts
        issue(4'd6, 8'h00, 8'h81, "R6 shl out");
        issue(4'd7, 8'h00, 8'h01, "R6 shr out zero");
        // R8 prefix feeds carry into shift
        issue(4'd0, 8'hFF, 8'h02, "R2 set carry");
        issue(4'd8, 8'h00, 8'h00, "R8 prefix quiet");
        issue(4'd6, 8'h00, 8'h40, "R8 shl uses carry");
        // R9 consumed by boolean
        issue(4'd0, 8'hFF, 8'h02, "R2 set carry");
        issue(4'd8, 8'h00, 8'h00, "R8 prefix");
        issue(4'd3, 8'hFF, 8'hFF, "R9 bool consumes");
        issue(4'd0, 8'h01, 8'h01, "R9 add back to default");
        // R9 idle cycles do not consume; prefix-prefix rearms
        issue(4'd0, 8'hFF, 8'h02, "R2 set carry");
        issue(4'd8, 8'h00, 8'h00, "R8 prefix");
        idle(3);
        issue(4'd8, 8'h00, 8'h00, "R9 rearm");
        issue(4'd0, 8'h01, 8'h01, "R9 add uses carry after idle");
        // R10 undefined opcode quiet, consumes
        issue(4'd0, 8'hFF, 8'h02, "R2 set carry");
        issue(4'd8, 8'h00, 8'h00, "R8 prefix");
        issue(4'd12, 8'h12, 8'h34, "R10 undefined quiet");
        issue(4'd15, 8'h00, 8'h00, "R10 undefined quiet");
        issue(4'd1, 8'h00, 8'h00, "R10 sub default after consume");
        idle(2);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            issue(op, 8'($urandom), 8'($urandom), "R2 R3 R5 R6 R8 R10 random mix");
        end
        idle(2);

        // R11 chains
        for (int i = 0; i < 40; i++) begin
            chain(2, 1'b0, 24'($urandom), 24'($urandom));
            chain(2, 1'b1, 24'($urandom), 24'($urandom));
            chain(3, 1'b0, 24'($urandom), 24'($urandom));
            chain(3, 1'b1, 24'($urandom), 24'($urandom));
        end
        chain(3, 1'b0, 24'hFFFFFF, 24'h000001);
        chain(3, 1'b1, 24'h000000, 24'h000001);

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule